// File: doc/BRIEF.md
# Bit-Level Serial EEPROM Responder

This block behaves as a small two-wire serial EEPROM of up to 256 bytes, seen from the bus side one sample at a time. A host presents the current clock and data line levels together with a qualifier. The block compares each sample with the previous one to find start conditions, stop conditions and clock rising edges. It uses one bit counter to frame a command byte and then a second byte. The second byte is an address when the command is a write, or outgoing read data when the command is a read.

A write command followed by an address byte sets the current address, and the byte stored there is then captured into an internal data register. A later read command shifts that captured byte out, most significant bit first, on the responder's data output. Each complete byte is followed by an acknowledge clock in which the responder pulls its data output low. The array is filled through a separate preload port, so the bus side never writes the memory.

Top module: `serial_eeprom_responder`

## Requirements
- R1: After synchronous reset the data output `sda_o` is 1, which is the released level.
- R2: A sample where SCL is high in both this sample and the previous one, and SDA falls, is a start. It arms framing and drops any pending acknowledge. A sample where SCL is high in both and SDA rises is a stop. It returns the block to idle and also drops any pending acknowledge.
- R3: While idle, meaning no start since reset or since the last stop, clock edges are ignored and `sda_o` stays 1.
- R4: After a start, the first 8 valid SCL rising edges shift SDA into the command byte, most significant bit first. On the 9th valid rising edge `sda_o` goes to 0 as the acknowledge, and it stays 0 until the next valid rising edge.
- R5: If command bit 0 is 0 (write), the next 8 valid rising edges shift SDA into the address, most significant bit first, and `sda_o` stays 1 during these edges.
- R6: If command bit 0 is 1 (read), each of the next 8 valid rising edges drives the data register's top bit onto `sda_o` and shifts the register left. The value holds until the next valid rising edge, and the address does not change.
- R7: When the 16th bit after a start has been taken, the data register loads the stored byte at the current address. So a write-address transaction followed by a read returns that byte, and a repeated read returns the same byte again.
- R8: The second byte of any command is followed by an acknowledge clock in which `sda_o` is 0.
- R9: A sample where SCL rises and SDA changes at the same time is an invalid edge. It shifts no bit and does not advance the bit count.
- R10: Valid rising edges after the second acknowledge keep `sda_o` at 1 and leave the address unchanged.
- R11: The preload port writes `pre_data` into location `pre_addr` when `pre_we` is 1. All 2^ADDR_W locations are reachable, including addresses 0x00 and 0xFF at the default width of 8.
- R12: A sample with `smp_valid` at 0 has no effect. It does not count as an edge, and it does not replace the stored previous line levels.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| smp_valid | input | 1 | Qualifies one line sample |
| scl_i | input | 1 | Sampled clock line level |
| sda_i | input | 1 | Sampled data line level |
| sda_o | output | 1 | Responder data drive (1 = released) |
| pre_we | input | 1 | Preload write enable |
| pre_addr | input | ADDR_W | Preload write address |
| pre_data | input | 8 | Preload write byte |

## Verification
Three kinds of transaction are run: write-address followed by read, back-to-back reads, and reads at the lowest and highest addresses. Together they separate a byte loaded from the collected address from one taken from a stale or shifted address. Further sequences check framing under disturbance. One stops partway through a command, one issues a repeated start after junk bits, one inserts an invalid edge into each byte, and one inserts samples with the qualifier low. In each case the acknowledge must appear on exactly the right clock, which exposes any miscount of bits. Clocks sent after the final acknowledge carry 1 bits, so any shift into the address would show up as a wrong byte on the next read.

// File: rtl/sep_pkg.sv
package sep_pkg;
  localparam int BYTE_W = 8;
  localparam int TICK_W = 5;
  // Bit count after a start: 1 = armed, 9 = command taken, 17 = second byte taken.
  localparam logic [TICK_W-1:0] TICK_IDLE      = TICK_W'(0);
  localparam logic [TICK_W-1:0] TICK_ARMED     = TICK_W'(1);
  localparam logic [TICK_W-1:0] TICK_CMD_LAST  = TICK_W'(BYTE_W);
  localparam logic [TICK_W-1:0] TICK_CMD_DONE  = TICK_W'(BYTE_W + 1);
  localparam logic [TICK_W-1:0] TICK_BYTE_LAST = TICK_W'(2 * BYTE_W);
  localparam logic [TICK_W-1:0] TICK_BYTE_DONE = TICK_W'(2 * BYTE_W + 1);
  localparam logic [TICK_W-1:0] TICK_PAST      = TICK_W'(2 * BYTE_W + 2);

  typedef struct packed {
    logic start;
    logic stop;
    logic bit_ok;
    logic bit_bad;
    logic bit_val;
  } bus_evt_t;
endpackage

// File: rtl/sep_line_sampler.sv
module sep_line_sampler
  import sep_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     smp_valid,
  input  logic     scl_i,
  input  logic     sda_i,
  output bus_evt_t evt
);
  logic prev_scl_q, prev_sda_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_scl_q <= 1'b1;
      prev_sda_q <= 1'b1;
    end else if (smp_valid) begin
      prev_scl_q <= scl_i;
      prev_sda_q <= sda_i;
    end
  end

  logic scl_hold, scl_rise, sda_moved;
  always_comb begin
    scl_hold    = smp_valid & prev_scl_q & scl_i;
    scl_rise    = smp_valid & ~prev_scl_q & scl_i;
    sda_moved   = prev_sda_q ^ sda_i;
    evt.start   = scl_hold & sda_moved & ~sda_i;
    evt.stop    = scl_hold & sda_moved & sda_i;
    evt.bit_ok  = scl_rise & ~sda_moved;
    evt.bit_bad = scl_rise & sda_moved;
    evt.bit_val = sda_i;
  end

  // R2 / R9: one sample never yields two kinds of event
  p_evt_excl_r2: assert property (@(posedge clk) disable iff (rst)
    $onehot0({evt.start, evt.stop, evt.bit_ok, evt.bit_bad}));

  // R12: an unqualified sample keeps the stored line levels
  p_hold_prev_r12: assert property (@(posedge clk) disable iff (rst)
    !smp_valid |=> $stable(prev_scl_q) && $stable(prev_sda_q));
endmodule

// File: rtl/sep_byte_store.sv
module sep_byte_store #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
    rd_data <= mem[rd_addr];
  end
endmodule

// File: rtl/sep_frame_engine.sv
module sep_frame_engine
  import sep_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  bus_evt_t          evt,
  input  logic [BYTE_W-1:0] rd_data,
  output logic [ADDR_W-1:0] rd_addr,
  output logic              sda_o
);
  logic [TICK_W-1:0] tick_q, tick_d;
  logic              ack_q, ack_d;
  logic [BYTE_W-1:0] cmd_q, cmd_d;
  logic [BYTE_W-1:0] addr_q, addr_d;
  logic [BYTE_W-1:0] data_q, data_d;
  logic              load_q, load_d;
  logic              sda_q, sda_d;
  logic              armed;

  always_comb begin
    tick_d = tick_q;
    ack_d  = ack_q;
    cmd_d  = cmd_q;
    addr_d = addr_q;
    data_d = data_q;
    sda_d  = sda_q;
    load_d = 1'b0;
    armed  = (tick_q != TICK_IDLE) || ack_q;

    if (evt.start) begin
      tick_d = TICK_ARMED;
      ack_d  = 1'b0;
      cmd_d  = '0;
      sda_d  = 1'b1;
    end else if (evt.stop) begin
      tick_d = TICK_IDLE;
      ack_d  = 1'b0;
      sda_d  = 1'b1;
    end else if (evt.bit_ok && armed) begin
      if (ack_q) begin
        sda_d = 1'b0;
        ack_d = 1'b0;
      end else if (tick_q < TICK_CMD_DONE) begin
        cmd_d  = {cmd_q[BYTE_W-2:0], evt.bit_val};
        tick_d = tick_q + TICK_W'(1);
        sda_d  = 1'b1;
        if (tick_q == TICK_CMD_LAST) ack_d = 1'b1;
      end else if (tick_q < TICK_BYTE_DONE) begin
        if (cmd_q[0]) begin
          sda_d  = data_q[BYTE_W-1];
          data_d = {data_q[BYTE_W-2:0], 1'b0};
        end else begin
          addr_d = {addr_q[BYTE_W-2:0], evt.bit_val};
          sda_d  = 1'b1;
        end
        tick_d = tick_q + TICK_W'(1);
        if (tick_q == TICK_BYTE_LAST) begin
          ack_d  = 1'b1;
          load_d = 1'b1;
        end
      end else begin
        sda_d  = 1'b1;
        tick_d = TICK_PAST;
      end
    end

    if (load_q) data_d = rd_data;
    rd_addr = addr_d[ADDR_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      tick_q <= TICK_IDLE;
      ack_q  <= 1'b0;
      cmd_q  <= '0;
      addr_q <= '0;
      data_q <= '0;
      load_q <= 1'b0;
      sda_q  <= 1'b1;
    end else begin
      tick_q <= tick_d;
      ack_q  <= ack_d;
      cmd_q  <= cmd_d;
      addr_q <= addr_d;
      data_q <= data_d;
      load_q <= load_d;
      sda_q  <= sda_d;
    end
  end

  assign sda_o = sda_q;

  // R3: idle keeps the line released
  p_idle_release_r3: assert property (@(posedge clk) disable iff (rst)
    (tick_q == TICK_IDLE) |-> sda_q);

  // R2: a start arms framing with no acknowledge pending
  p_start_arms_r2: assert property (@(posedge clk) disable iff (rst)
    evt.start |=> (tick_q == TICK_ARMED) && !ack_q);

  // R4 / R8: a pending acknowledge is driven low on the next good edge
  p_ack_low_r4: assert property (@(posedge clk) disable iff (rst)
    (evt.bit_ok && ack_q) |=> !sda_q);

  // R9: an invalid edge changes no framing state
  p_bad_edge_r9: assert property (@(posedge clk) disable iff (rst)
    evt.bit_bad |=> $stable(tick_q) && $stable(cmd_q) && $stable(addr_q) && $stable(sda_q));

  // R10: past the second byte the line stays released and the address holds
  p_past_release_r10: assert property (@(posedge clk) disable iff (rst)
    (tick_q == TICK_PAST) |-> sda_q);
  p_past_addr_r10: assert property (@(posedge clk) disable iff (rst)
    (tick_q == TICK_PAST) |=> $stable(addr_q));
endmodule

// File: rtl/serial_eeprom_responder.sv
module serial_eeprom_responder
  import sep_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              smp_valid,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_o,
  input  logic              pre_we,
  input  logic [ADDR_W-1:0] pre_addr,
  input  logic [7:0]        pre_data
);
  bus_evt_t          evt;
  logic [ADDR_W-1:0] rd_addr;
  logic [BYTE_W-1:0] rd_data;

  sep_line_sampler u_sampler (
    .clk       (clk),
    .rst       (rst),
    .smp_valid (smp_valid),
    .scl_i     (scl_i),
    .sda_i     (sda_i),
    .evt       (evt)
  );

  sep_byte_store #(.ADDR_W(ADDR_W), .DATA_W(BYTE_W)) u_store (
    .clk     (clk),
    .wr_en   (pre_we),
    .wr_addr (pre_addr),
    .wr_data (pre_data),
    .rd_addr (rd_addr),
    .rd_data (rd_data)
  );

  sep_frame_engine #(.ADDR_W(ADDR_W)) u_engine (
    .clk     (clk),
    .rst     (rst),
    .evt     (evt),
    .rd_data (rd_data),
    .rd_addr (rd_addr),
    .sda_o   (sda_o)
  );
endmodule

// File: tb/serial_eeprom_responder_tb.sv
module serial_eeprom_responder_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       smp_valid = 1'b0;
  logic       scl_i = 1'b1;
  logic       sda_i = 1'b1;
  logic       sda_o;
  logic       pre_we = 1'b0;
  logic [7:0] pre_addr = '0;
  logic [7:0] pre_data = '0;

  int  vec = 0;
  int  bad = 0;
  bit  done = 0;

  always #5 clk = ~clk;

  serial_eeprom_responder u_dut (
    .clk(clk), .rst(rst), .smp_valid(smp_valid), .scl_i(scl_i), .sda_i(sda_i),
    .sda_o(sda_o), .pre_we(pre_we), .pre_addr(pre_addr), .pre_data(pre_data)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    vec++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic put(input logic c, input logic d, input logic v = 1'b1);
    @(negedge clk);
    scl_i = c; sda_i = d; smp_valid = v;
    @(negedge clk);
    smp_valid = 1'b0;
  endtask

  task automatic clk_bit(input logic b, output logic seen);
    put(1'b0, b);
    put(1'b1, b);
    seen = sda_o;
  endtask

  task automatic bad_edge(input logic b);
    put(1'b0, b);
    put(1'b1, ~b);
  endtask

  task automatic bus_start();
    put(1'b0, 1'b1); put(1'b1, 1'b1); put(1'b1, 1'b0);
  endtask

  task automatic bus_stop();
    put(1'b0, 1'b0); put(1'b1, 1'b0); put(1'b1, 1'b1);
  endtask

  // Sends a byte; returns OR of inverted outputs (1 if any low) and the ack level.
  task automatic send_byte(input logic [7:0] b, input int bad_at,
                           output logic any_low, output logic ack);
    logic s;
    any_low = 1'b0;
    for (int i = 7; i >= 0; i--) begin
      if (i == bad_at) bad_edge(b[i]);
      clk_bit(b[i], s);
      if (!s) any_low = 1'b1;
    end
    clk_bit(1'b1, ack);
  endtask

  task automatic set_addr(input logic [7:0] a, input int bad_at, input string req);
    logic low, ack;
    bus_start();
    send_byte(8'hA0, -1, low, ack);
    chk({req, " R4 command ack"}, {7'd0, ack}, 8'h00);
    send_byte(a, bad_at, low, ack);
    chk({req, " R5 released during address"}, {7'd0, low}, 8'h00);
    chk({req, " R8 address ack"}, {7'd0, ack}, 8'h00);
    bus_stop();
  endtask

  task automatic read_byte(output logic [7:0] got, output logic ack_c, output logic ack_d);
    logic low, s;
    bus_start();
    send_byte(8'hA1, -1, low, ack_c);
    for (int i = 7; i >= 0; i--) begin
      clk_bit(1'b1, s);
      got[i] = s;
    end
    clk_bit(1'b1, ack_d);
    bus_stop();
  endtask

  task automatic preload(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    pre_we = 1'b1; pre_addr = a; pre_data = d;
    @(negedge clk);
    pre_we = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1 reset level", {7'd0, sda_o}, 8'h01);
  endtask

  task automatic t_preload();
    preload(8'h5A, 8'hC3);
    preload(8'h00, 8'h81);
    preload(8'hFF, 8'h7E);
    preload(8'h33, 8'hA5);
  endtask

  task automatic t_idle();
    logic s, low;
    low = 1'b0;
    for (int i = 0; i < 20; i++) begin
      clk_bit(1'b0, s);
      if (!s) low = 1'b1;
    end
    chk("R3 idle ignores clocks", {7'd0, low}, 8'h00);
  endtask

  task automatic t_write_read();
    logic [7:0] got;
    logic a1, a2;
    set_addr(8'h5A, -1, "wr");
    read_byte(got, a1, a2);
    chk("R4 read command ack", {7'd0, a1}, 8'h00);
    chk("R6 R7 read byte at 0x5A", got, 8'hC3);
    chk("R8 ack after read data", {7'd0, a2}, 8'h00);
    read_byte(got, a1, a2);
    chk("R7 repeated read same byte", got, 8'hC3);
  endtask

  task automatic t_bounds();
    logic [7:0] got;
    logic a1, a2;
    set_addr(8'h00, -1, "lo");
    read_byte(got, a1, a2);
    chk("R11 byte at 0x00", got, 8'h81);
    set_addr(8'hFF, -1, "hi");
    read_byte(got, a1, a2);
    chk("R11 byte at 0xFF", got, 8'h7E);
  endtask

  task automatic t_stop_mid();
    logic s, low;
    bus_start();
    for (int i = 0; i < 4; i++) clk_bit(1'b0, s);
    bus_stop();
    low = 1'b0;
    for (int i = 0; i < 12; i++) begin
      clk_bit(1'b0, s);
      if (!s) low = 1'b1;
    end
    chk("R2 stop returns to idle", {7'd0, low}, 8'h00);
  endtask

  task automatic t_restart();
    logic s, low, ack;
    logic [7:0] got;
    logic a1, a2;
    bus_start();
    for (int i = 0; i < 5; i++) clk_bit(1'b0, s);
    bus_start();
    send_byte(8'hA0, -1, low, ack);
    chk("R2 repeated start reframes command", {7'd0, ack}, 8'h00);
    send_byte(8'h33, -1, low, ack);
    chk("R2 address ack after restart", {7'd0, ack}, 8'h00);
    bus_stop();
    read_byte(got, a1, a2);
    chk("R2 byte at 0x33 after restart", got, 8'hA5);
  endtask

  task automatic t_bad_edge();
    logic low, ack;
    logic [7:0] got;
    logic a1, a2;
    bus_start();
    send_byte(8'hA0, 4, low, ack);
    chk("R9 command ack after invalid edge", {7'd0, ack}, 8'h00);
    send_byte(8'hFF, 2, low, ack);
    chk("R9 address ack after invalid edge", {7'd0, ack}, 8'h00);
    bus_stop();
    read_byte(got, a1, a2);
    chk("R9 address unaffected by invalid edge", got, 8'h7E);
  endtask

  task automatic t_past();
    logic low, ack, s;
    logic [7:0] got;
    logic a1, a2;
    bus_start();
    send_byte(8'hA0, -1, low, ack);
    send_byte(8'h00, -1, low, ack);
    low = 1'b0;
    for (int i = 0; i < 6; i++) begin
      clk_bit(1'b1, s);
      if (!s) low = 1'b1;
    end
    chk("R10 released past second byte", {7'd0, low}, 8'h00);
    bus_stop();
    read_byte(got, a1, a2);
    chk("R10 address kept past second byte", got, 8'h81);
  endtask

  task automatic t_valid();
    logic s;
    logic [7:0] cmd;
    cmd = 8'hA0;
    bus_start();
    for (int i = 7; i >= 1; i--) clk_bit(cmd[i], s);
    put(1'b0, 1'b0, 1'b0);
    put(1'b1, 1'b0, 1'b0);
    clk_bit(cmd[0], s);
    chk("R12 unqualified edge not counted", {7'd0, s}, 8'h01);
    clk_bit(1'b1, s);
    chk("R12 ack on ninth qualified edge", {7'd0, s}, 8'h00);
    bus_stop();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_preload();
    t_idle();
    t_write_read();
    t_bounds();
    t_stop_mid();
    t_restart();
    t_bad_edge();
    t_past();
    t_valid();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      vec++;
      bad++;
      $display("FAIL watchdog actual=%h expected=%h", 8'h00, 8'h01);
      $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
      $finish;
    end
  end
endmodule